// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the fetch-side control state of a multithreaded pipeline front end. For every hardware thread it keeps a small state machine and four sticky stall flags, one for each downstream stage (decode, rename, execute, commit). Each cycle it combines the stall flags, the context-switch flag, squash requests from commit and decode, the reorder buffer's still-squashing indication, instruction-cache request and response events, and trap, quiesce and wake events. From these it decides each thread's next state and redirect PC.

A request tag is kept per thread. Each accepted cache request takes the thread's current tag and then advances it. A response is honoured only if the thread is still waiting and the response carries the tag of the outstanding request. Any other response is discarded and flagged. After an honoured response the stall condition is checked again before the thread may resume. A single stage-active output tells the surrounding pipeline whether any enabled thread can make fetch progress. The fetch of the line itself and branch prediction are handled elsewhere.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset every thread is in Running (state code 0), its PC equals RESET_PC, its next PC equals RESET_PC+4 and its issue tag is 0. State codes are: 0 Running, 1 Idle, 2 Squashing, 3 Blocked, 4 WaitResponse, 5 AccessDone, 6 TrapPending, 7 QuiescePending.
- R2: Each stage's stall flag is set by its block pulse and cleared by its unblock pulse. A thread stays Blocked while any flag is still set. An unblock pulse while the flag is clear, or together with a block pulse for the same stage, is illegal.
- R3: Each cycle the per-thread conditions are weighed in this order: commit squash, then reorder-buffer squashing, then decode squash, then stall, then return from Blocked or Squashing to Running, then the cache, fetch-turn, idle, trap, quiesce, issue and wake events.
- R4: A commit squash loads the commit redirect PC, sets next PC to that value plus 4, abandons any outstanding request and enters Squashing on the next cycle.
- R5: A decode squash loads its redirect PC and enters Squashing only when the thread is not already Squashing. Otherwise the PC is left unchanged.
- R6: When any stall flag (after this cycle's pulses) or the context-switch input is set, the thread enters Blocked, except when it is in WaitResponse, where it stays.
- R7: A response for a thread that is not in WaitResponse, or whose tag differs from the outstanding tag, changes no state. It raises resp_drop_o for one cycle, one cycle after the response.
- R8: An accepted response moves the thread to Blocked if its stall condition holds and to AccessDone otherwise. AccessDone becomes Running on the thread's fetch turn.
- R9: stage_active_o is high exactly when some thread whose active input is set is in Running, Squashing or AccessDone.
- R10: A request issued while Running moves the thread to WaitResponse and increments that thread's issue tag by one, modulo 2^TAG_W.
- R11: From Running, a trap event enters TrapPending and a quiesce event enters QuiescePending. A wake event returns either one to Running.
- R12: A Running thread whose active input is low enters Idle. An Idle thread whose active input is high returns to Running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| blk_dec_i | input | NT | Decode block pulse per thread |
| unblk_dec_i | input | NT | Decode unblock pulse per thread |
| blk_ren_i | input | NT | Rename block pulse per thread |
| unblk_ren_i | input | NT | Rename unblock pulse per thread |
| blk_exe_i | input | NT | Execute block pulse per thread |
| unblk_exe_i | input | NT | Execute unblock pulse per thread |
| blk_cmt_i | input | NT | Commit block pulse per thread |
| unblk_cmt_i | input | NT | Commit unblock pulse per thread |
| cmt_squash_i | input | NT | Squash request from commit |
| cmt_pc_i | input | NT*PC_W | Commit redirect PC per thread |
| rob_squashing_i | input | NT | Reorder buffer still squashing |
| dec_squash_i | input | NT | Squash request from decode |
| dec_pc_i | input | NT*PC_W | Decode redirect PC per thread |
| ctx_switch_i | input | 1 | Context switch in progress (stalls all threads) |
| thread_active_i | input | NT | Thread enabled |
| req_issue_i | input | NT | Cache request issued |
| resp_valid_i | input | 1 | Cache response present |
| resp_tid_i | input | TID_W | Thread of the response |
| resp_tag_i | input | TAG_W | Tag carried by the response |
| fetch_turn_i | input | NT | Thread's fetch turn this cycle |
| trap_i | input | NT | Trap event |
| quiesce_i | input | NT | Quiesce event |
| wake_i | input | NT | Wake event |
| thread_state_o | output | NT*3 | State code per thread |
| thread_pc_o | output | NT*PC_W | Redirected PC per thread |
| thread_npc_o | output | NT*PC_W | Next PC per thread |
| issue_tag_o | output | NT*TAG_W | Tag the next request of each thread carries |
| stage_active_o | output | 1 | Some enabled thread can make progress |
| resp_drop_o | output | 1 | A response was discarded last cycle |

## Verification
A wrong state code shows on thread_state_o one cycle after the input that caused it. Because every later transition depends on the current state, the mismatch then tends to spread. A corrupted stall flag shows up as a thread that is Blocked, or not Blocked, in the cycle after the next pulse or event. A wrong tag shows either on issue_tag_o right after an issue, or as a wrong resp_drop_o or AccessDone when the matching response arrives. Comparing every output on every cycle against a behavioural model therefore catches any divergence within one cycle of the point where it becomes visible.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_SQUASH  = 3'd2,
    ST_BLOCK   = 3'd3,
    ST_WAIT    = 3'd4,
    ST_DONE    = 3'd5,
    ST_TRAP    = 3'd6,
    ST_QUIESCE = 3'd7
  } fetch_st_e;

  localparam int unsigned NUM_STALL_SRC = 4;
  localparam int unsigned INST_BYTES    = 4;
  localparam int unsigned ST_W          = 3;
endpackage

// File: rtl/fsc_stall_flags.sv
module fsc_stall_flags #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] blk_i,
  input  logic [NSRC-1:0] unblk_i,
  input  logic            ctx_i,
  output logic            stall_o
);
  logic [NSRC-1:0] flag_q, flag_nx, flag_en;

  always_comb begin
    flag_en = blk_i | unblk_i;
    flag_nx = (flag_q | blk_i) & ~unblk_i;
    stall_o = (|flag_nx) | ctx_i;
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[k] <= 1'b0;
      end else if (flag_en[k]) begin
        flag_q[k] <= flag_nx[k];
      end
    end

    // R2: unblock only while the flag is set and no block arrives with it
    p_unblk_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      unblk_i[k] |-> (flag_q[k] && !blk_i[k]));
  end
endmodule

// File: rtl/fsc_tag_track.sv
module fsc_tag_track #(
  parameter int unsigned TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic [TAG_W-1:0] resp_tag_i,
  output logic [TAG_W-1:0] issue_tag_o,
  output logic             match_o
);
  logic [TAG_W-1:0] next_q, pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0;
      pend_q <= '0;
    end else if (issue_i) begin
      next_q <= next_q + 1'b1;
      pend_q <= next_q;
    end
  end

  assign issue_tag_o = next_q;
  assign match_o     = (resp_tag_i == pend_q);

  // R10: every issue advances the tag by one
  p_tag_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> issue_tag_o == TAG_W'($past(issue_tag_o) + 1'b1));
endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
  import fsc_pkg::*;
#(
  parameter int unsigned      PC_W     = 32,
  parameter logic [PC_W-1:0]  RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall_i,
  input  logic            cmt_sq_i,
  input  logic [PC_W-1:0] cmt_pc_i,
  input  logic            rob_sq_i,
  input  logic            dec_sq_i,
  input  logic [PC_W-1:0] dec_pc_i,
  input  logic            resp_any_i,
  input  logic            resp_hit_i,
  input  logic            turn_i,
  input  logic            active_i,
  input  logic            trap_i,
  input  logic            quiesce_i,
  input  logic            wake_i,
  input  logic            req_i,
  output logic [ST_W-1:0] state_o,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] npc_o,
  output logic            issue_o,
  output logic            drop_o,
  output logic            run_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

  fetch_st_e       st_q, st_nx;
  logic [PC_W-1:0] pc_q, npc_q, redir_pc;
  logic            pc_en, accept;

  always_comb begin
    st_nx    = st_q;
    pc_en    = 1'b0;
    redir_pc = cmt_pc_i;
    accept   = 1'b0;
    issue_o  = 1'b0;
    if (cmt_sq_i) begin
      st_nx = ST_SQUASH;
      pc_en = 1'b1;
    end else if (rob_sq_i) begin
      st_nx = ST_SQUASH;
    end else if (dec_sq_i && st_q != ST_SQUASH) begin
      st_nx    = ST_SQUASH;
      pc_en    = 1'b1;
      redir_pc = dec_pc_i;
    end else if (stall_i && st_q != ST_WAIT) begin
      st_nx = ST_BLOCK;
    end else if (st_q == ST_BLOCK || st_q == ST_SQUASH) begin
      st_nx = ST_RUN;
    end else if (st_q == ST_WAIT && resp_hit_i) begin
      accept = 1'b1;
      st_nx  = stall_i ? ST_BLOCK : ST_DONE;
    end else if (st_q == ST_DONE && turn_i) begin
      st_nx = ST_RUN;
    end else if (st_q == ST_RUN && !active_i) begin
      st_nx = ST_IDLE;
    end else if (st_q == ST_IDLE && active_i) begin
      st_nx = ST_RUN;
    end else if (st_q == ST_RUN && trap_i) begin
      st_nx = ST_TRAP;
    end else if (st_q == ST_RUN && quiesce_i) begin
      st_nx = ST_QUIESCE;
    end else if (st_q == ST_RUN && req_i) begin
      st_nx   = ST_WAIT;
      issue_o = 1'b1;
    end else if ((st_q == ST_TRAP || st_q == ST_QUIESCE) && wake_i) begin
      st_nx = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_RUN;
    end else begin
      st_q <= st_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      npc_q <= RESET_PC + STEP;
    end else if (pc_en) begin
      pc_q  <= redir_pc;
      npc_q <= redir_pc + STEP;
    end
  end

  assign state_o = st_q;
  assign pc_o    = pc_q;
  assign npc_o   = npc_q;
  assign drop_o  = resp_any_i && !accept;
  assign run_o   = active_i &&
                   (st_q == ST_RUN || st_q == ST_SQUASH || st_q == ST_DONE);

  // R4: commit squash redirects PC and next PC and enters Squashing
  p_cmt_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_sq_i |=> (st_q == ST_SQUASH && pc_o == $past(cmt_pc_i)
                  && npc_o == $past(cmt_pc_i) + STEP));

  // R5: decode squash while Squashing leaves the PC alone
  p_dec_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SQUASH && dec_sq_i && !cmt_sq_i) |=> pc_o == $past(pc_o));

  // R6: a stalled thread that is not waiting becomes Blocked
  p_stall_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && st_q != ST_WAIT && !cmt_sq_i && !rob_sq_i && !dec_sq_i)
      |=> st_q == ST_BLOCK);

  // R6: a waiting thread stays waiting until a response or a squash
  p_wait_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !cmt_sq_i && !rob_sq_i && !dec_sq_i && !resp_hit_i)
      |=> st_q == ST_WAIT);

  // R8: an honoured response ends in Blocked or AccessDone
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && resp_hit_i && !cmt_sq_i && !rob_sq_i && !dec_sq_i)
      |=> (st_q == ST_BLOCK || st_q == ST_DONE));
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
  import fsc_pkg::*;
#(
  parameter int unsigned     NT       = 2,
  parameter int unsigned     PC_W     = 32,
  parameter int unsigned     TAG_W    = 4,
  parameter logic [PC_W-1:0] RESET_PC = 32'h0000_0100,
  localparam int unsigned    TID_W    = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NT-1:0]      blk_dec_i,
  input  logic [NT-1:0]      unblk_dec_i,
  input  logic [NT-1:0]      blk_ren_i,
  input  logic [NT-1:0]      unblk_ren_i,
  input  logic [NT-1:0]      blk_exe_i,
  input  logic [NT-1:0]      unblk_exe_i,
  input  logic [NT-1:0]      blk_cmt_i,
  input  logic [NT-1:0]      unblk_cmt_i,
  input  logic [NT-1:0]      cmt_squash_i,
  input  logic [NT*PC_W-1:0] cmt_pc_i,
  input  logic [NT-1:0]      rob_squashing_i,
  input  logic [NT-1:0]      dec_squash_i,
  input  logic [NT*PC_W-1:0] dec_pc_i,
  input  logic               ctx_switch_i,
  input  logic [NT-1:0]      thread_active_i,
  input  logic [NT-1:0]      req_issue_i,
  input  logic               resp_valid_i,
  input  logic [TID_W-1:0]   resp_tid_i,
  input  logic [TAG_W-1:0]   resp_tag_i,
  input  logic [NT-1:0]      fetch_turn_i,
  input  logic [NT-1:0]      trap_i,
  input  logic [NT-1:0]      quiesce_i,
  input  logic [NT-1:0]      wake_i,
  output logic [NT*ST_W-1:0] thread_state_o,
  output logic [NT*PC_W-1:0] thread_pc_o,
  output logic [NT*PC_W-1:0] thread_npc_o,
  output logic [NT*TAG_W-1:0] issue_tag_o,
  output logic               stage_active_o,
  output logic               resp_drop_o
);
  logic          rst_meta_q, rst_sync_q;
  logic [NT-1:0] run_v, drop_v;
  logic          drop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic stall, issue, match, resp_any;

    assign resp_any = resp_valid_i && (resp_tid_i == TID_W'(t));

    fsc_stall_flags #(.NSRC(NUM_STALL_SRC)) u_flags (
      .clk     (clk),
      .rst_n   (rst_sync_q),
      .blk_i   ({blk_cmt_i[t], blk_exe_i[t], blk_ren_i[t], blk_dec_i[t]}),
      .unblk_i ({unblk_cmt_i[t], unblk_exe_i[t], unblk_ren_i[t], unblk_dec_i[t]}),
      .ctx_i   (ctx_switch_i),
      .stall_o (stall)
    );

    fsc_tag_track #(.TAG_W(TAG_W)) u_tag (
      .clk         (clk),
      .rst_n       (rst_sync_q),
      .issue_i     (issue),
      .resp_tag_i  (resp_tag_i),
      .issue_tag_o (issue_tag_o[t*TAG_W +: TAG_W]),
      .match_o     (match)
    );

    fsc_thread_fsm #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_sync_q),
      .stall_i    (stall),
      .cmt_sq_i   (cmt_squash_i[t]),
      .cmt_pc_i   (cmt_pc_i[t*PC_W +: PC_W]),
      .rob_sq_i   (rob_squashing_i[t]),
      .dec_sq_i   (dec_squash_i[t]),
      .dec_pc_i   (dec_pc_i[t*PC_W +: PC_W]),
      .resp_any_i (resp_any),
      .resp_hit_i (resp_any && match),
      .turn_i     (fetch_turn_i[t]),
      .active_i   (thread_active_i[t]),
      .trap_i     (trap_i[t]),
      .quiesce_i  (quiesce_i[t]),
      .wake_i     (wake_i[t]),
      .req_i      (req_issue_i[t]),
      .state_o    (thread_state_o[t*ST_W +: ST_W]),
      .pc_o       (thread_pc_o[t*PC_W +: PC_W]),
      .npc_o      (thread_npc_o[t*PC_W +: PC_W]),
      .issue_o    (issue),
      .drop_o     (drop_v[t]),
      .run_o      (run_v[t])
    );
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      drop_q <= 1'b0;
    end else begin
      drop_q <= |drop_v;
    end
  end

  assign resp_drop_o    = drop_q;
  assign stage_active_o = |run_v;

  // R7: a valid response is either honoured by its thread or reported dropped
  p_drop_pulse_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (resp_valid_i && $countones(drop_v) == 0) |=> !resp_drop_o);

  // R7: at most one thread can drop a response in a cycle
  p_drop_single_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0(drop_v));
endmodule

// File: tb/fetch_status_ctrl_tb.sv
module fetch_status_ctrl_tb;
  localparam int T  = 2;
  localparam int PW = 32;
  localparam int TW = 4;
  localparam logic [PW-1:0] RPC = 32'h0000_0100;

  localparam int S_RUN = 0, S_IDLE = 1, S_SQ = 2, S_BLK = 3,
                 S_WAIT = 4, S_DONE = 5, S_TRAP = 6, S_QUI = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic [T-1:0] blk_dec, unblk_dec, blk_ren, unblk_ren, blk_exe, unblk_exe, blk_cmt, unblk_cmt;
  logic [T-1:0] cmt_sq, rob_sq, dec_sq, active, req, turn, trap, qui, wake;
  logic [T*PW-1:0] cmt_pc, dec_pc;
  logic ctx, rv;
  logic [0:0] rtid;
  logic [TW-1:0] rtag;
  logic [T*3-1:0] st_o;
  logic [T*PW-1:0] pc_o, npc_o;
  logic [T*TW-1:0] tag_o;
  logic act_o, drop_o;

  always #5 clk = ~clk;

  fetch_status_ctrl #(.NT(T), .PC_W(PW), .TAG_W(TW), .RESET_PC(RPC)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .blk_dec_i(blk_dec), .unblk_dec_i(unblk_dec), .blk_ren_i(blk_ren), .unblk_ren_i(unblk_ren),
    .blk_exe_i(blk_exe), .unblk_exe_i(unblk_exe), .blk_cmt_i(blk_cmt), .unblk_cmt_i(unblk_cmt),
    .cmt_squash_i(cmt_sq), .cmt_pc_i(cmt_pc), .rob_squashing_i(rob_sq),
    .dec_squash_i(dec_sq), .dec_pc_i(dec_pc), .ctx_switch_i(ctx),
    .thread_active_i(active), .req_issue_i(req), .resp_valid_i(rv),
    .resp_tid_i(rtid), .resp_tag_i(rtag), .fetch_turn_i(turn),
    .trap_i(trap), .quiesce_i(qui), .wake_i(wake),
    .thread_state_o(st_o), .thread_pc_o(pc_o), .thread_npc_o(npc_o),
    .issue_tag_o(tag_o), .stage_active_o(act_o), .resp_drop_o(drop_o)
  );

  // behavioural reference model
  int          m_st[T];
  logic [PW-1:0] m_pc[T], m_npc[T];
  bit          m_fl[T][4];
  int          m_tag[T], m_pend[T];
  bit          m_drop;
  bit          model_on = 1'b0;

  int n_chk = 0, n_fail = 0;

  task automatic chk(string req_tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req_tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < T; t++) begin
        m_st[t] = S_RUN; m_pc[t] = RPC; m_npc[t] = RPC + 4;
        m_tag[t] = 0; m_pend[t] = 0;
        for (int k = 0; k < 4; k++) m_fl[t][k] = 1'b0;
      end
      m_drop = 1'b0;
    end else begin
      bit dn;
      dn = 1'b0;
      for (int t = 0; t < T; t++) begin
        bit bl[4], ub[4], stall, acc, mine;
        int s;
        bl[0] = blk_dec[t]; bl[1] = blk_ren[t]; bl[2] = blk_exe[t]; bl[3] = blk_cmt[t];
        ub[0] = unblk_dec[t]; ub[1] = unblk_ren[t]; ub[2] = unblk_exe[t]; ub[3] = unblk_cmt[t];
        stall = ctx;
        for (int k = 0; k < 4; k++) begin
          if (bl[k]) m_fl[t][k] = 1'b1;
          if (ub[k]) m_fl[t][k] = 1'b0;
          if (m_fl[t][k]) stall = 1'b1;
        end
        s = m_st[t];
        acc = 1'b0;
        mine = rv && (int'(rtid) == t);
        if (cmt_sq[t]) begin
          s = S_SQ; m_pc[t] = cmt_pc[t*PW +: PW]; m_npc[t] = m_pc[t] + 4;
        end else if (rob_sq[t]) s = S_SQ;
        else if (dec_sq[t] && m_st[t] != S_SQ) begin
          s = S_SQ; m_pc[t] = dec_pc[t*PW +: PW]; m_npc[t] = m_pc[t] + 4;
        end else if (stall && m_st[t] != S_WAIT) s = S_BLK;
        else if (m_st[t] == S_BLK || m_st[t] == S_SQ) s = S_RUN;
        else if (m_st[t] == S_WAIT && mine && int'(rtag) == m_pend[t]) begin
          acc = 1'b1; s = stall ? S_BLK : S_DONE;
        end else if (m_st[t] == S_DONE && turn[t]) s = S_RUN;
        else if (m_st[t] == S_RUN && !active[t]) s = S_IDLE;
        else if (m_st[t] == S_IDLE && active[t]) s = S_RUN;
        else if (m_st[t] == S_RUN && trap[t]) s = S_TRAP;
        else if (m_st[t] == S_RUN && qui[t]) s = S_QUI;
        else if (m_st[t] == S_RUN && req[t]) begin
          s = S_WAIT; m_pend[t] = m_tag[t]; m_tag[t] = (m_tag[t] + 1) % (1 << TW);
        end else if ((m_st[t] == S_TRAP || m_st[t] == S_QUI) && wake[t]) s = S_RUN;
        m_st[t] = s;
        if (mine && !acc) dn = 1'b1;
      end
      m_drop = dn;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      bit a;
      a = 1'b0;
      for (int t = 0; t < T; t++) begin
        chk("R3 state", st_o[t*3 +: 3], m_st[t]);
        chk("R4 pc", pc_o[t*PW +: PW], m_pc[t]);
        chk("R4 npc", npc_o[t*PW +: PW], m_npc[t]);
        chk("R10 tag", tag_o[t*TW +: TW], m_tag[t]);
        if (active[t] && (m_st[t] == S_RUN || m_st[t] == S_SQ || m_st[t] == S_DONE)) a = 1'b1;
      end
      chk("R9 active", act_o, a);
      chk("R7 drop", drop_o, m_drop);
    end
  end

  task automatic clr();
    blk_dec = '0; unblk_dec = '0; blk_ren = '0; unblk_ren = '0;
    blk_exe = '0; unblk_exe = '0; blk_cmt = '0; unblk_cmt = '0;
    cmt_sq = '0; rob_sq = '0; dec_sq = '0; req = '0; turn = '0;
    trap = '0; qui = '0; wake = '0; ctx = 1'b0; rv = 1'b0;
    rtid = '0; rtag = '0; cmt_pc = '0; dec_pc = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    clr();
  endtask

  function automatic longint st0();
    return st_o[2:0];
  endfunction

  function automatic longint st1();
    return st_o[5:3];
  endfunction

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    clr();
    active = '1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_on = 1'b1;

    // R1 reset state
    chk("R1 state t0", st0(), S_RUN);
    chk("R1 state t1", st1(), S_RUN);
    chk("R1 pc", pc_o[PW-1:0], RPC);
    chk("R1 npc", npc_o[PW-1:0], RPC + 4);
    chk("R1 tag", tag_o[TW-1:0], 0);

    // R2 / R6 stall flags
    blk_dec[0] = 1'b1; step();
    chk("R6 blocked", st0(), S_BLK);
    blk_ren[0] = 1'b1; step();
    unblk_dec[0] = 1'b1; step();
    chk("R2 still blocked", st0(), S_BLK);
    unblk_ren[0] = 1'b1; step();
    chk("R2 released", st0(), S_RUN);

    // R3 / R4 commit squash wins over decode squash
    cmt_sq[0] = 1'b1; cmt_pc[PW-1:0] = 32'h1000;
    dec_sq[0] = 1'b1; dec_pc[PW-1:0] = 32'h2000; step();
    chk("R3 squash", st0(), S_SQ);
    chk("R4 pc", pc_o[PW-1:0], 32'h1000);
    chk("R4 npc", npc_o[PW-1:0], 32'h1004);

    // R5 decode squash while squashing ignored
    dec_sq[0] = 1'b1; dec_pc[PW-1:0] = 32'h3000; step();
    chk("R5 pc kept", pc_o[PW-1:0], 32'h1000);
    chk("R5 state", st0(), S_RUN);

    // R3 reorder-buffer squash over decode squash
    rob_sq[0] = 1'b1; dec_sq[0] = 1'b1; dec_pc[PW-1:0] = 32'h4000; step();
    chk("R3 rob", st0(), S_SQ);
    chk("R3 rob pc", pc_o[PW-1:0], 32'h1000);
    step();

    // R10 / R9 / R7 / R8
    req = 2'b11; step();
    chk("R10 wait", st0(), S_WAIT);
    chk("R10 tag inc", tag_o[TW-1:0], 1);
    chk("R9 idle stage", act_o, 0);
    blk_exe[0] = 1'b1; step();
    chk("R6 wait kept", st0(), S_WAIT);
    rv = 1'b1; rtid = 1'b0; rtag = 4'h5; step();
    chk("R7 stale kept", st0(), S_WAIT);
    chk("R7 drop", drop_o, 1);
    rv = 1'b1; rtid = 1'b0; rtag = 4'h0; step();
    chk("R8 to blocked", st0(), S_BLK);
    chk("R7 no drop", drop_o, 0);
    unblk_exe[0] = 1'b1; step();
    rv = 1'b1; rtid = 1'b1; rtag = 4'h0; step();
    chk("R8 done", st1(), S_DONE);
    chk("R9 active", act_o, 1);
    turn[1] = 1'b1; step();
    chk("R8 resume", st1(), S_RUN);

    // R11 trap / quiesce
    trap[0] = 1'b1; step();
    chk("R11 trap", st0(), S_TRAP);
    wake[0] = 1'b1; step();
    chk("R11 wake", st0(), S_RUN);
    qui[0] = 1'b1; step();
    chk("R11 quiesce", st0(), S_QUI);
    wake[0] = 1'b1; step();
    chk("R11 wake2", st0(), S_RUN);

    // R12 idle
    active[0] = 1'b0; step();
    chk("R12 idle", st0(), S_IDLE);
    active[0] = 1'b1; step();
    chk("R12 back", st0(), S_RUN);

    // R6 context switch
    ctx = 1'b1; step();
    chk("R6 ctx t0", st0(), S_BLK);
    chk("R6 ctx t1", st1(), S_BLK);
    step();
    chk("R6 ctx over", st0(), S_RUN);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      for (int t = 0; t < T; t++) begin
        bit b;
        b = ($urandom % 12) == 0; blk_dec[t] = b;
        unblk_dec[t] = !b && m_fl[t][0] && ($urandom % 4 == 0);
        b = ($urandom % 12) == 0; blk_ren[t] = b;
        unblk_ren[t] = !b && m_fl[t][1] && ($urandom % 4 == 0);
        b = ($urandom % 12) == 0; blk_exe[t] = b;
        unblk_exe[t] = !b && m_fl[t][2] && ($urandom % 4 == 0);
        b = ($urandom % 12) == 0; blk_cmt[t] = b;
        unblk_cmt[t] = !b && m_fl[t][3] && ($urandom % 4 == 0);
        cmt_sq[t] = ($urandom % 20) == 0;
        cmt_pc[t*PW +: PW] = $urandom;
        rob_sq[t] = ($urandom % 30) == 0;
        dec_sq[t] = ($urandom % 15) == 0;
        dec_pc[t*PW +: PW] = $urandom;
        req[t] = $urandom % 2;
        turn[t] = $urandom % 2;
        trap[t] = ($urandom % 50) == 0;
        qui[t] = ($urandom % 50) == 0;
        wake[t] = ($urandom % 6) == 0;
        if ($urandom % 40 == 0) active[t] = !active[t];
      end
      ctx = ($urandom % 40) == 0;
      rv = ($urandom % 3) == 0;
      rtid = 1'($urandom % T);
      rtag = ($urandom % 2) ? TW'(m_pend[rtid]) : TW'($urandom);
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule